// File: doc/BRIEF.md
# Virtual Supervisor Top-Interrupt Selector

This block works out which interrupt a virtualized supervisor level sees as its highest pending one. It then decides whether the hart should be asked to trap into that level. A hypervisor can force an interrupt identity and priority through its interrupt-control fields. When virtual trapping is enabled, that forced interrupt wins without regard to any pending, enable or delegation state. A forced supervisor external interrupt (identity 9) follows its own rule: it is honoured only while virtual trapping is off, and only if the guest has enabled bit 9. When neither forced case applies, the block scans the guest's pending-and-enabled vectors in a fixed order.

The selected interrupt is packed into a 32-bit top-interrupt read value. The same value, qualified by the current privilege mode and the guest's global interrupt enable, drives a trap request that is registered once. The trap request therefore follows any input change one cycle later. A third output tells the CSR path to divert guest accesses to the supervisor pending and enable registers to the hypervisor whenever virtual trapping is on. The parameter `HARDWIRED_MASK` lists vector bits that an implementation ties to zero. Bit 9 is exempt from that mask.

Top module: `vs_topi_sel`

## Requirements
- R1: When `vti_en`=1 and `inj_iid`≠9, the injected interrupt is selected with identity `inj_iid` and priority `inj_prio`. `vs_pend` and `vs_en` have no effect on the result.
- R2: When `vti_en`=0 and `inj_iid`=9, an injected interrupt with identity 9 is selected only if `vs_en[9]`=1. Otherwise the vectors decide.
- R3: `acc_trap` equals `vti_en` at all times.
- R4: `trap_req` is 1 one clock cycle after a cycle in which all three conditions hold: `cur_mode`=3'b011 (virtual supervisor), `vs_gie`=1, and `top_val`≠0. If any of the three fails, `trap_req` is 0 one cycle later.
- R5: `trap_req` stays 0 in machine (3'b000), hypervisor-supervisor (3'b001), user (3'b010) and virtual user (3'b100) modes, whatever `top_val` is.
- R6: Bit 9 of the vectors always takes part in the scan, even when `HARDWIRED_MASK` has bit 9 set. The default mask has only bit 9 set.
- R7: `top_val` holds the identity in bits 27:16 and the priority in bits 7:0. Bits 31:28 and 15:8 are 0, and the whole value is 0 when no candidate is valid.
- R8: The vector scan looks only at bits 9, 1 and 5 of `vs_pend & vs_en`, in that order of precedence. All other bits are ignored.
- R9: A candidate from the vectors reports priority 1.
- R10: When `inj_dflt`=1, an injected candidate reports priority 255, whatever `inj_prio` holds.
- R11: When `vti_en`=1 and `inj_iid`=9, the injected interrupt is not a candidate and the vector scan decides.
- R12: While `rst` is 1, `trap_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vti_en | input | 1 | Hypervisor virtual-trap enable |
| inj_iid | input | 12 | Injected interrupt identity |
| inj_prio | input | 8 | Injected interrupt priority |
| inj_dflt | input | 1 | Report the injected interrupt at the lowest priority (255) |
| vs_pend | input | VEC_W | Effective guest supervisor pending vector |
| vs_en | input | VEC_W | Effective guest supervisor enable vector |
| cur_mode | input | 3 | Current privilege mode: 000 M, 001 HS, 010 U, 011 VS, 100 VU |
| vs_gie | input | 1 | Guest supervisor global interrupt enable |
| top_val | output | 32 | Top-interrupt read value |
| trap_req | output | 1 | Registered request to trap into the virtual supervisor level |
| acc_trap | output | 1 | Divert guest accesses to the supervisor pending and enable registers |

## Verification
Directed patterns cover the following cases:
- An injection with all vectors clear, and one with all vectors set, to show that the vectors do not matter.
- Identity 9 with bit 9 of `vs_en` both clear and set, and with `vti_en` high and low, to separate the external-interrupt rule from the general one.
- Vector words with several of bits 9, 1 and 5 live, which expose the scan order, and words with only unscanned bits set, which must read as zero.
- Each privilege mode with the global enable on and off, plus an injection of identity 0 at priority 0, which must give a zero top value and no trap.

Seeded random words over all inputs are then checked against a model of the selection rule.

// File: rtl/vs_topi_pkg.sv
package vs_topi_pkg;

    localparam int IID_W  = 12;
    localparam int PRIO_W = 8;
    localparam int TOP_W  = 32;
    localparam int SCAN_N = 3;
    localparam int SEI_NUM = 9;

    localparam logic [IID_W-1:0]  SEI_ID      = IID_W'(SEI_NUM);
    localparam logic [PRIO_W-1:0] PRIO_LOWEST = '1;
    localparam logic [PRIO_W-1:0] PRIO_VEC    = PRIO_W'(1);

    typedef enum logic [2:0] {
        MODE_M  = 3'b000,
        MODE_HS = 3'b001,
        MODE_U  = 3'b010,
        MODE_VS = 3'b011,
        MODE_VU = 3'b100
    } mode_e;

    typedef struct packed {
        logic              valid;
        logic [IID_W-1:0]  iid;
        logic [PRIO_W-1:0] prio;
    } cand_t;

    // Vector bit inspected at scan position k (position 0 wins).
    function automatic int scan_bit(input int k);
        case (k)
            0:       return 9;
            1:       return 1;
            default: return 5;
        endcase
    endfunction

    function automatic logic [TOP_W-1:0] pack_top(input cand_t c);
        logic [TOP_W-1:0] v;
        v = '0;
        if (c.valid) begin
            v[27:16] = c.iid;
            v[7:0]   = c.prio;
        end
        return v;
    endfunction

endpackage

// File: rtl/vs_topi_inj.sv
module vs_topi_inj
    import vs_topi_pkg::*;
(
    input  logic              vti_en,
    input  logic [IID_W-1:0]  inj_iid,
    input  logic [PRIO_W-1:0] inj_prio,
    input  logic              inj_dflt,
    input  logic              sei_enabled,
    output cand_t             cand
);
    logic is_sei;
    logic forced;
    logic sei_forced;

    always_comb begin
        is_sei     = (inj_iid == SEI_ID);
        forced     = vti_en && !is_sei;
        sei_forced = !vti_en && is_sei && sei_enabled;
        cand.valid = forced || sei_forced;
        cand.iid   = inj_iid;
        cand.prio  = inj_dflt ? PRIO_LOWEST : inj_prio;
    end
endmodule

// File: rtl/vs_topi_scan.sv
module vs_topi_scan
    import vs_topi_pkg::*;
#(
    parameter int              VEC_W          = 16,
    parameter logic [VEC_W-1:0] HARDWIRED_MASK = '0
) (
    input  logic [VEC_W-1:0] vs_pend,
    input  logic [VEC_W-1:0] vs_en,
    output cand_t            cand
);
    localparam logic [VEC_W-1:0] ONE  = VEC_W'(1);
    localparam logic [VEC_W-1:0] KEEP = ~HARDWIRED_MASK | (ONE << SEI_NUM);

    logic [VEC_W-1:0] live;
    logic [SCAN_N-1:0] hit;
    logic [IID_W-1:0]  pos_iid [SCAN_N];

    assign live = vs_pend & vs_en & KEEP;

    for (genvar k = 0; k < SCAN_N; k++) begin : g_pos
        assign hit[k]     = live[scan_bit(k)];
        assign pos_iid[k] = IID_W'(scan_bit(k));
    end

    always_comb begin
        cand = '0;
        for (int k = SCAN_N - 1; k >= 0; k--) begin
            if (hit[k]) begin
                cand.valid = 1'b1;
                cand.iid   = pos_iid[k];
                cand.prio  = PRIO_VEC;
            end
        end
    end
endmodule

// File: rtl/vs_topi_trap.sv
module vs_topi_trap
    import vs_topi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cur_mode,
    input  logic       vs_gie,
    input  logic       top_nz,
    output logic       trap_req
);
    logic want;

    assign want = (mode_e'(cur_mode) == MODE_VS) && vs_gie && top_nz;

    always_ff @(posedge clk) begin
        if (rst) trap_req <= 1'b0;
        else     trap_req <= want;
    end
endmodule

// File: rtl/vs_topi_sel.sv
module vs_topi_sel
    import vs_topi_pkg::*;
#(
    parameter int               VEC_W          = 16,
    parameter logic [VEC_W-1:0] HARDWIRED_MASK = VEC_W'(1) << 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vti_en,
    input  logic [11:0]       inj_iid,
    input  logic [7:0]        inj_prio,
    input  logic              inj_dflt,
    input  logic [VEC_W-1:0]  vs_pend,
    input  logic [VEC_W-1:0]  vs_en,
    input  logic [2:0]        cur_mode,
    input  logic              vs_gie,
    output logic [31:0]       top_val,
    output logic              trap_req,
    output logic              acc_trap
);
    cand_t inj_c;
    cand_t vec_c;
    cand_t sel_c;

    vs_topi_inj u_inj (
        .vti_en      (vti_en),
        .inj_iid     (inj_iid),
        .inj_prio    (inj_prio),
        .inj_dflt    (inj_dflt),
        .sei_enabled (vs_en[SEI_NUM]),
        .cand        (inj_c)
    );

    vs_topi_scan #(
        .VEC_W          (VEC_W),
        .HARDWIRED_MASK (HARDWIRED_MASK)
    ) u_scan (
        .vs_pend (vs_pend),
        .vs_en   (vs_en),
        .cand    (vec_c)
    );

    assign sel_c    = inj_c.valid ? inj_c : vec_c;
    assign top_val  = pack_top(sel_c);
    assign acc_trap = vti_en;

    vs_topi_trap u_trap (
        .clk      (clk),
        .rst      (rst),
        .cur_mode (cur_mode),
        .vs_gie   (vs_gie),
        .top_nz   (|top_val),
        .trap_req (trap_req)
    );
endmodule

// File: rtl/vs_topi_chk.sv
module vs_topi_chk #(
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             vti_en,
    input logic [11:0]      inj_iid,
    input logic [7:0]       inj_prio,
    input logic             inj_dflt,
    input logic [VEC_W-1:0] vs_pend,
    input logic [VEC_W-1:0] vs_en,
    input logic [2:0]       cur_mode,
    input logic             vs_gie,
    input logic [31:0]      top_val,
    input logic             trap_req,
    input logic             acc_trap
);
    p_inject_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        (vti_en && inj_iid != 12'd9) |-> (top_val[27:16] == inj_iid));

    p_sei_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (!vti_en && inj_iid == 12'd9 && vs_en[9]) |-> (top_val[27:16] == 12'd9));

    p_acc_flag_r3: assert property (@(posedge clk) disable iff (rst)
        acc_trap == vti_en);

    p_trap_req_r4: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'b011 && vs_gie && top_val != 32'd0) |=> trap_req);

    p_no_trap_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_mode != 3'b011) |=> !trap_req);

    p_format_r7: assert property (@(posedge clk) disable iff (rst)
        (top_val[31:28] == 4'd0) && (top_val[15:8] == 8'd0));

    p_vec_prio_r9: assert property (@(posedge clk) disable iff (rst)
        (!vti_en && inj_iid != 12'd9 && top_val != 32'd0) |-> (top_val[7:0] == 8'd1));

    p_dflt_prio_r10: assert property (@(posedge clk) disable iff (rst)
        (vti_en && inj_iid != 12'd9 && inj_dflt) |-> (top_val[7:0] == 8'hFF));

    p_reset_r12: assert property (@(posedge clk)
        rst |=> !trap_req);
endmodule

bind vs_topi_sel vs_topi_chk #(.VEC_W(VEC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .vti_en   (vti_en),
    .inj_iid  (inj_iid),
    .inj_prio (inj_prio),
    .inj_dflt (inj_dflt),
    .vs_pend  (vs_pend),
    .vs_en    (vs_en),
    .cur_mode (cur_mode),
    .vs_gie   (vs_gie),
    .top_val  (top_val),
    .trap_req (trap_req),
    .acc_trap (acc_trap)
);

// File: tb/tb_vs_topi_sel.sv
module tb_vs_topi_sel;
    localparam int VEC_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             vti_en;
    logic [11:0]      inj_iid;
    logic [7:0]       inj_prio;
    logic             inj_dflt;
    logic [VEC_W-1:0] vs_pend;
    logic [VEC_W-1:0] vs_en;
    logic [2:0]       cur_mode;
    logic             vs_gie;
    logic [31:0]      top_val;
    logic             trap_req;
    logic             acc_trap;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    vs_topi_sel #(.VEC_W(VEC_W)) dut (
        .clk(clk), .rst(rst), .vti_en(vti_en), .inj_iid(inj_iid),
        .inj_prio(inj_prio), .inj_dflt(inj_dflt), .vs_pend(vs_pend),
        .vs_en(vs_en), .cur_mode(cur_mode), .vs_gie(vs_gie),
        .top_val(top_val), .trap_req(trap_req), .acc_trap(acc_trap)
    );

    function automatic logic [31:0] mk(input logic [11:0] id, input logic [7:0] pr);
        logic [31:0] v;
        v = '0;
        v[27:16] = id;
        v[7:0]   = pr;
        return v;
    endfunction

    function automatic logic [31:0] model_top(
        input logic vti, input logic [11:0] id, input logic [7:0] pr,
        input logic dflt, input logic [VEC_W-1:0] p, input logic [VEC_W-1:0] e);
        logic [VEC_W-1:0] live;
        if ((vti && id != 12'd9) || (!vti && id == 12'd9 && e[9]))
            return mk(id, dflt ? 8'hFF : pr);
        live = p & e;
        if (live[9]) return mk(12'd9, 8'd1);
        if (live[1]) return mk(12'd1, 8'd1);
        if (live[5]) return mk(12'd5, 8'd1);
        return 32'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called right after a falling edge: drive, check the combinational
    // outputs, then check the registered trap request one edge later.
    task automatic apply(input string req, input logic vti, input logic [11:0] id,
                         input logic [7:0] pr, input logic dflt,
                         input logic [VEC_W-1:0] p, input logic [VEC_W-1:0] e,
                         input logic [2:0] md, input logic gie);
        logic [31:0] et;
        logic        etrap;
        vti_en = vti; inj_iid = id; inj_prio = pr; inj_dflt = dflt;
        vs_pend = p; vs_en = e; cur_mode = md; vs_gie = gie;
        et    = model_top(vti, id, pr, dflt, p, e);
        etrap = (md == 3'b011) && gie && (et != 32'd0);
        #1;
        check(req, top_val, et);
        check("R3 acc_trap", {31'd0, acc_trap}, {31'd0, vti});
        @(posedge clk);
        @(negedge clk);
        check(md == 3'b011 ? "R4 trap_req" : "R5 trap_req", {31'd0, trap_req}, {31'd0, etrap});
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst = 1'b1;
        vti_en = 1'b1; inj_iid = 12'd5; inj_prio = 8'd3; inj_dflt = 1'b0;
        vs_pend = '1; vs_en = '1; cur_mode = 3'b011; vs_gie = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 reset trap_req", {31'd0, trap_req}, 32'd0);
        rst = 1'b0;

        // R1: injection ignores vectors (all clear, then all set)
        apply("R1 inject clear vec", 1, 12'd3, 8'd7, 0, '0, '0, 3'b011, 1);
        apply("R1 inject full vec", 1, 12'd3, 8'd7, 0, '1, '1, 3'b011, 1);
        // R10: default-priority rule
        apply("R10 dflt prio", 1, 12'd11, 8'd4, 1, '0, '0, 3'b011, 1);
        // R2: identity 9 with bit 9 enable clear then set
        apply("R2 sei en clear", 0, 12'd9, 8'd6, 0, '0, '0, 3'b011, 1);
        apply("R2 sei en set", 0, 12'd9, 8'd6, 0, '0, 16'h0200, 3'b011, 1);
        // R11: identity 9 with virtual trap on falls back to vectors
        apply("R11 sei vti on", 1, 12'd9, 8'd6, 0, 16'h0020, 16'h0020, 3'b011, 1);
        apply("R11 sei vti on none", 1, 12'd9, 8'd6, 0, '0, 16'h0200, 3'b011, 1);
        // R8/R9: scan order and vector priority
        apply("R8 order 1 over 5", 0, 12'd0, 8'd0, 0, 16'h0022, 16'h0022, 3'b011, 1);
        apply("R8 order 9 first", 0, 12'd0, 8'd0, 0, 16'h0222, 16'h0222, 3'b011, 1);
        apply("R9 bit5 prio", 0, 12'd2, 8'd9, 0, 16'h0020, 16'hFFFF, 3'b011, 1);
        apply("R8 unscanned bits", 0, 12'd0, 8'd0, 0, 16'hFDDD, 16'hFFFF, 3'b011, 1);
        // R6: bit 9 live despite hardwired mask listing it
        apply("R6 bit9 masked", 0, 12'd0, 8'd0, 0, 16'h0200, 16'h0200, 3'b011, 1);
        // R7: zero injected identity and priority gives zero value
        apply("R7 zero inject", 1, 12'd0, 8'd0, 0, '1, '1, 3'b011, 1);
        // R4: global enable off
        apply("R4 gie off", 1, 12'd3, 8'd7, 0, '0, '0, 3'b011, 0);
        // R5: other modes
        apply("R5 mode M", 1, 12'd3, 8'd7, 0, '0, '0, 3'b000, 1);
        apply("R5 mode HS", 1, 12'd3, 8'd7, 0, '0, '0, 3'b001, 1);
        apply("R5 mode U", 1, 12'd3, 8'd7, 0, '0, '0, 3'b010, 1);
        apply("R5 mode VU", 1, 12'd3, 8'd7, 0, '0, '0, 3'b100, 1);

        for (int i = 0; i < 400; i++) begin
            logic [11:0] id;
            logic [2:0]  md;
            case ($urandom % 4)
                0:       id = 12'd9;
                1:       id = 12'($urandom % 16);
                default: id = 12'($urandom);
            endcase
            md = 3'($urandom % 5);
            if ($urandom % 2 == 0) md = 3'b011;
            apply("R7 random", 1'($urandom), id, 8'($urandom), 1'($urandom),
                  16'($urandom), 16'($urandom), md, 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule